// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the front end of a single-channel transmit DMA. Host software builds a ring of 16-byte descriptors in memory. Each descriptor holds a status/control word, a tag word, and the low and high words of a buffer address. The software then writes to a poll register. The engine walks the ring from its current index. For every descriptor that hardware owns, it reads the buffer through a word memory port and sends the frame out on a byte stream toward the MAC. When the frame is out, it writes the status word back with ownership cleared. The walk stops at the first descriptor that software still owns.

Control bits in the status word decide the flow. Bit 31 is ownership. Bit 30 is end of ring. Bits 29 and 28 mark the first and last segment of a frame. Bits 12:0 hold the byte length. A frame carried in a single buffer that is shorter than 60 bytes is stretched to 60 bytes with zero fill. The ring base is aligned to 256 bytes. The engine reads only the status word and the low buffer-address word. It reports a busy level, a one-cycle done pulse for each descriptor returned, a sticky transmit-OK flag and its current ring index.

Top module: `tx_desc_poll_engine`

## Requirements
- R1: After reset, tx_valid, busy and done are 0, mem_rd and mem_wr are 0, tx_ok is 0 and ring_idx is 0.
- R2: A cycle with poll_wr high and poll_data bit 6 set starts a scan. A poll write with bit 6 clear is ignored: busy stays 0 and no byte is sent.
- R3: The descriptor for index i sits at (ring_base with bits 7:0 forced to 0) + 16*i. Its status word is at offset 0 and its buffer address at offset 8. Bits 1:0 of the buffer address are ignored.
- R4: If the status word at the current index has bit 31 clear, the scan ends with no byte sent, no write to memory, and ring_idx unchanged.
- R5: Frame bytes go out least-significant byte first from each 32-bit buffer word, in increasing address order. The byte count is status bits 12:0.
- R6: When status bits 29 and 28 are both set and the length is below 60, exactly 60 bytes go out, and the bytes past the stored length are 0x00. Descriptors without both bits send exactly their length.
- R7: tx_last is high on the final byte of a descriptor whose bit 28 is set, and low on every other byte.
- R8: After a descriptor's bytes, the status word is written back with bit 31 cleared and every other bit unchanged. done is high for exactly that cycle. tx_ok then reads 1 until the next poll write with bit 6 set clears it.
- R9: After each returned descriptor, ring_idx goes to 0 if status bit 30 was set or the index was at its maximum (15 by default). Otherwise it goes up by one.
- R10: A scan processes consecutive owned descriptors back to back until it meets one with bit 31 clear.
- R11: A poll write with bit 6 set that arrives while a scan is running causes one further scan to start right after the current one ends.
- R12: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values and tx_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_wr | input | 1 | Poll register write strobe |
| poll_data | input | 8 | Poll register write data; bit 6 requests a scan |
| ring_base | input | AW | Descriptor ring base byte address; bits 7:0 ignored |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | AW | Memory byte address of the word |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of a frame |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when a descriptor is returned |
| tx_ok | output | 1 | Sticky transmit-OK flag |
| ring_idx | output | IDX_W | Current ring index |

## Verification
The assertions assume that the memory returns read data exactly one cycle after mem_rd. They also assume that ring_base and the descriptor being processed do not change while busy is high. The bench keeps to this in three ways. Its memory model has a fixed one-cycle latency. It writes descriptors and changes the ring base only after the engine has been idle for several cycles. Its one mid-scan poll write touches no memory. Backpressure on tx_ready comes from a shift-register pattern, so the hold rule is exercised often without ever stalling the stream for good.

// File: rtl/txp_pkg.sv
package txp_pkg;
    // Descriptor status word layout
    localparam int OWN_BIT   = 31;
    localparam int EOR_BIT   = 30;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT  = 28;
    localparam int LEN_W     = 13;
    localparam int MIN_FRAME = 60;
    // Descriptor geometry
    localparam int BUF_OFS    = 8;
    localparam int DESC_SHIFT = 4;
    localparam int ALIGN_BITS = 8;
    localparam int LANES      = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RSTAT, ST_CHK, ST_RBUF, ST_GBUF,
        ST_FETCH, ST_LOAD, ST_SEND, ST_WB
    } state_t;

    typedef struct packed {
        logic own;
        logic eor;
        logic first;
        logic last;
    } flags_t;

    function automatic flags_t flags_of(input logic [31:0] s);
        flags_t f;
        f.own   = s[OWN_BIT];
        f.eor   = s[EOR_BIT];
        f.first = s[FIRST_BIT];
        f.last  = s[LAST_BIT];
        return f;
    endfunction

    function automatic logic [LEN_W-1:0] padded_len(input logic [LEN_W-1:0] raw,
                                                    input logic single);
        return (single && raw < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : raw;
    endfunction
endpackage

// File: rtl/txp_ring_index.sv
module txp_ring_index #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (adv)
            idx <= (wrap || idx == IDX_MAX) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/txp_byte_lane.sv
module txp_byte_lane #(
    parameter int LANES = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word,
    input  logic [SEL_W-1:0]   sel,
    input  logic               zero,
    output logic [7:0]         byte_out
);
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[8*g +: 8];
    end

    assign byte_out = zero ? 8'h00 : lane[sel];
endmodule

// File: rtl/tx_desc_poll_engine.sv
module tx_desc_poll_engine
    import txp_pkg::*;
#(
    parameter int AW       = 32,
    parameter int IDX_W    = 4,
    parameter int POLL_BIT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          poll_wr,
    input  logic [7:0]    poll_data,
    input  logic [AW-1:0] ring_base,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          busy,
    output logic          done,
    output logic          tx_ok,
    output logic [IDX_W-1:0] ring_idx
);
    localparam logic [AW-1:0] BASE_MASK = {{(AW-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
    localparam logic [AW-1:0] WORD_MASK = {{(AW-2){1'b1}}, 2'b00};
    localparam int SEL_W = $clog2(LANES);

    state_t           st;
    logic [31:0]      stat_q;
    logic [AW-1:0]    buf_q;
    logic [LEN_W-1:0] cnt_q;
    logic [31:0]      word_q;
    logic             pend_q;
    logic             txok_q;

    logic             unused_poll;
    assign unused_poll = ^poll_data;

    wire poll_go = poll_wr & poll_data[POLL_BIT];

    flags_t           fl;
    logic [LEN_W-1:0] raw_len, eff_len;
    logic [LEN_W:0]   cnt_nx;
    logic             end_byte, in_data, nxt_in_data, word_end;
    logic [AW-1:0]    desc_base;

    assign fl          = flags_of(stat_q);
    assign raw_len     = stat_q[LEN_W-1:0];
    assign eff_len     = padded_len(raw_len, fl.first & fl.last);
    assign cnt_nx      = {1'b0, cnt_q} + (LEN_W+1)'(1);
    assign end_byte    = (cnt_q == eff_len - LEN_W'(1));
    assign in_data     = (cnt_q < raw_len);
    assign nxt_in_data = (cnt_nx < {1'b0, raw_len});
    assign word_end    = (cnt_q[SEL_W-1:0] == {SEL_W{1'b1}});
    assign desc_base   = (ring_base & BASE_MASK) + AW'({ring_idx, {DESC_SHIFT{1'b0}}});

    txp_ring_index #(.IDX_W(IDX_W)) u_idx (
        .clk  (clk),
        .rst  (rst),
        .adv  (st == ST_WB),
        .wrap (fl.eor),
        .idx  (ring_idx)
    );

    txp_byte_lane #(.LANES(LANES)) u_lane (
        .word     (word_q),
        .sel      (cnt_q[SEL_W-1:0]),
        .zero     (!in_data),
        .byte_out (tx_data)
    );

    always_comb begin
        mem_rd    = (st == ST_RSTAT) || (st == ST_RBUF) || (st == ST_FETCH);
        mem_wr    = (st == ST_WB);
        mem_wdata = stat_q & ~(32'h1 << OWN_BIT);
        case (st)
            ST_RSTAT, ST_WB: mem_addr = desc_base;
            ST_RBUF:         mem_addr = desc_base + AW'(BUF_OFS);
            ST_FETCH:        mem_addr = buf_q + AW'(cnt_q);
            default:         mem_addr = '0;
        endcase
        tx_valid = (st == ST_SEND);
        tx_last  = (st == ST_SEND) && end_byte && fl.last;
        busy     = (st != ST_IDLE);
        done     = (st == ST_WB);
        tx_ok    = txok_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            stat_q <= '0;
            buf_q  <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            pend_q <= 1'b0;
            txok_q <= 1'b0;
        end else begin
            if (poll_go && st != ST_IDLE) pend_q <= 1'b1;
            else if (st == ST_IDLE)       pend_q <= 1'b0;

            if (st == ST_WB)   txok_q <= 1'b1;
            else if (poll_go)  txok_q <= 1'b0;

            case (st)
                ST_IDLE:  if (poll_go || pend_q) st <= ST_RSTAT;
                ST_RSTAT: st <= ST_CHK;
                ST_CHK: begin
                    stat_q <= mem_rdata;
                    st     <= mem_rdata[OWN_BIT] ? ST_RBUF : ST_IDLE;
                end
                ST_RBUF:  st <= ST_GBUF;
                ST_GBUF: begin
                    buf_q <= mem_rdata[AW-1:0] & WORD_MASK;
                    cnt_q <= '0;
                    if (eff_len == '0) begin
                        st <= ST_WB;
                    end else if (raw_len == '0) begin
                        word_q <= '0;
                        st     <= ST_SEND;
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                ST_FETCH: st <= ST_LOAD;
                ST_LOAD: begin
                    word_q <= mem_rdata;
                    st     <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    cnt_q <= cnt_nx[LEN_W-1:0];
                    if (end_byte) begin
                        st <= ST_WB;
                    end else if (word_end) begin
                        if (nxt_in_data) st <= ST_FETCH;
                        else             word_q <= '0;
                    end
                end
                ST_WB:    st <= ST_RSTAT;
                default:  st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txp_checker.sv
module txp_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             done,
    input logic             tx_ok,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [31:0]      mem_wdata,
    input logic             busy,
    input logic [IDX_W-1:0] ring_idx
);
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_wb_own_clear_r8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_wdata[31] && done);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_txok_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> tx_ok);

    p_idx_step_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (ring_idx == $past(ring_idx) + 1'b1) || (ring_idx == '0));

    p_idx_still_r4: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(ring_idx));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_valid && !mem_rd && !mem_wr);

    p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    p_port_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind tx_desc_poll_engine txp_checker #(.IDX_W(IDX_W)) u_txp_checker (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .done      (done),
    .tx_ok     (tx_ok),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .ring_idx  (ring_idx)
);

// File: tb/tb_tx_desc_poll_engine.sv
module tb_tx_desc_poll_engine;
    localparam int AW = 32;
    localparam int IDX_W = 4;
    localparam int DESC0 = 32'h200;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          poll_wr = 1'b0;
    logic [7:0]    poll_data = '0;
    logic [AW-1:0] ring_base = DESC0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          tx_valid, tx_last, busy, done, tx_ok;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data;
    logic [IDX_W-1:0] ring_idx;

    tx_desc_poll_engine #(.AW(AW), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .poll_wr(poll_wr), .poll_data(poll_data),
        .ring_base(ring_base), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .busy(busy), .done(done), .tx_ok(tx_ok),
        .ring_idx(ring_idx)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] mdl [0:1023];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
        if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
    end

    logic [8:0] expq [$];
    int checks = 0, fails = 0, n_done = 0, busy_rises = 0, cyc = 0;
    int exp_idx = 0, exp_done = 0;
    logic exp_ok = 1'b0;
    logic busy_d = 1'b0;
    logic slow = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // per-clock comparison of the byte stream against the reference queue
    always @(negedge clk) begin
        logic [8:0] e;
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = slow ? (lfsr[0] | lfsr[3]) : 1'b1;
        if (!rst) begin
            if (done) n_done++;
            if (busy && !busy_d) busy_rises++;
            busy_d = busy;
            if (tx_valid && tx_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R5 unexpected byte", {23'h0, tx_last, tx_data}, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk({tx_last, tx_data} == e, "R5/R6/R7 stream byte",
                        {23'h0, tx_last, tx_data}, {23'h0, e});
                end
            end
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic wr_desc(input int k, input logic [31:0] st, input logic [31:0] bufa);
        int w;
        w = (DESC0 + 16 * k) >> 2;
        mem[w] = st;       mdl[w] = st;
        mem[w + 1] = '0;   mdl[w + 1] = '0;
        mem[w + 2] = bufa; mdl[w + 2] = bufa;
        mem[w + 3] = '0;   mdl[w + 3] = '0;
    endtask

    // behavioural model of one scan, applied to the mirror
    task automatic model_scan(input logic [31:0] base);
        int a, len, eff, b, cnt;
        logic [31:0] st, w;
        logic single;
        cnt = 0;
        for (int n = 0; n < 64; n++) begin
            a = (base & 32'hFFFF_FF00) + exp_idx * 16;
            st = mdl[a >> 2];
            if (!st[31]) break;
            len = int'(st[12:0]);
            single = st[29] & st[28];
            eff = (single && len < 60) ? 60 : len;
            b = mdl[(a >> 2) + 2] & 32'hFFFF_FFFC;
            for (int i = 0; i < eff; i++) begin
                w = mdl[(b + (i & ~3)) >> 2];
                expq.push_back({(i == eff - 1) && st[28],
                                (i < len) ? w[8 * (i % 4) +: 8] : 8'h00});
            end
            mdl[a >> 2] = st & 32'h7FFF_FFFF;
            exp_done++;
            cnt++;
            exp_idx = (st[30] || exp_idx == 15) ? 0 : exp_idx + 1;
        end
        exp_ok = (cnt > 0);
    endtask

    task automatic do_poll(input logic [7:0] d, input logic [31:0] base);
        @(negedge clk);
        ring_base = base;
        if (d[6]) model_scan(base);
        poll_wr = 1'b1;
        poll_data = d;
        @(negedge clk);
        poll_wr = 1'b0;
        poll_data = '0;
    endtask

    task automatic wait_idle();
        int q;
        q = 0;
        while (q < 8) begin
            @(negedge clk);
            q = busy ? 0 : q + 1;
        end
    endtask

    task automatic final_check(input string tag);
        bit same;
        same = 1'b1;
        for (int k = 0; k < 64; k++)
            if (mem[(DESC0 >> 2) + k] !== mdl[(DESC0 >> 2) + k]) same = 1'b0;
        chk(expq.size() == 0, {tag, " R5 all bytes sent"}, expq.size(), 0);
        chk(n_done == exp_done, {tag, " R8 done pulses"}, n_done, exp_done);
        chk(ring_idx == exp_idx[IDX_W-1:0], {tag, " R9 ring index"}, ring_idx, exp_idx);
        chk(tx_ok == exp_ok, {tag, " R8 tx_ok"}, tx_ok, exp_ok);
        chk(same, {tag, " R8 descriptor write-back"}, same, 1);
    endtask

    initial begin
        int r0;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = {i[7:0] ^ 8'h3C, i[7:0] + 8'h11, ~i[7:0], i[7:0] ^ 8'hC5};
            mdl[i] = mem[i];
        end
        for (int i = DESC0 >> 2; i < (DESC0 >> 2) + 64; i++) begin
            mem[i] = '0;
            mdl[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!tx_valid && !busy && !done && !mem_rd && !mem_wr, "R1 idle outputs",
            {tx_valid, busy, done, mem_rd, mem_wr}, 0);
        chk(tx_ok == 1'b0, "R1 tx_ok", tx_ok, 0);
        chk(ring_idx == '0, "R1 ring_idx", ring_idx, 0);

        // R2 poll write without bit 6 is ignored (descriptor 0 owned)
        wr_desc(0, 32'hB000_0000 | 100, 32'h400);
        do_poll(8'hBF, DESC0);
        repeat (10) @(negedge clk);
        chk(busy_rises == 0, "R2 no scan without bit 6", busy_rises, 0);
        chk(expq.size() == 0 && n_done == 0, "R2 no output", n_done, 0);

        // R5 R8 single frame of 100 bytes
        do_poll(8'h40, DESC0);
        wait_idle();
        final_check("T3");

        // R6 short single frame padded to 60
        wr_desc(1, 32'hB000_0000 | 20, 32'h480);
        do_poll(8'h40, DESC0);
        wait_idle();
        final_check("T4");

        // R4 unowned descriptor: no output, index unchanged, tx_ok cleared
        do_poll(8'h40, DESC0);
        wait_idle();
        final_check("T5 R4");
        chk(ring_idx == 2, "R4 index unchanged", ring_idx, 2);

        // R7 R10 R3 two-segment frame, unaligned ring base and buffer address
        slow = 1'b1;
        wr_desc(2, 32'hA000_0000 | 10, 32'h500);
        wr_desc(3, 32'h9000_0000 | 7, 32'h583);
        do_poll(8'h40, 32'h2C4);
        wait_idle();
        final_check("T6 R3 R7 R10");

        // R9 end-of-ring wrap
        wr_desc(4, 32'hF000_0000 | 61, 32'h600);
        do_poll(8'h40, DESC0);
        wait_idle();
        final_check("T7 R9");
        chk(ring_idx == 0, "R9 wrap on end-of-ring", ring_idx, 0);

        // R11 poll during a scan causes one more scan
        wr_desc(0, 32'hB000_0000 | 100, 32'h680);
        r0 = busy_rises;
        do_poll(8'h40, DESC0);
        while (!tx_valid) @(negedge clk);
        do_poll(8'h40, DESC0);
        wait_idle();
        exp_ok = 1'b1;
        chk(busy_rises == r0 + 2, "R11 rescan after poll while busy", busy_rises, r0 + 2);
        final_check("T8 R11");

        // R9 R10 full ring, wrap at the maximum index without end-of-ring
        for (int k = 0; k < 16; k++)
            wr_desc(k, 32'hB000_0000 | (60 + k), 32'h400 + 32'h80 * k);
        do_poll(8'h40, DESC0);
        wait_idle();
        final_check("T9 R9 R10");
        chk(ring_idx == 1, "R9 wrap at maximum index", ring_idx, 1);

        finish_run();
    end
endmodule